// File: doc/BRIEF.md
# Half-Duplex SPI Master Engine

This block is an SPI master for a chip's control plane. It runs one transaction per start request. Software first loads a write buffer of up to eight bytes and sets the configuration inputs. It then pulses `start`. The engine shifts out the requested number of write frames and then shifts in the requested number of read frames into a read buffer. The two phases never overlap, so the bus is half duplex. Each frame has its own length of 1 to 8 bits.

Timing is set in core clock cycles by four values:
- a setup delay before the first bit period;
- a hold delay after the last bit period;
- an idle gap between frames of the same direction;
- a separate turnaround gap between the last write frame and the first read frame.

SCK runs at the core clock divided by a power of two, and all four clock polarity and phase modes are supported. The chip-select outputs are plain registered copies of software select bits, so a select can stay asserted across several transactions. When a transaction ends, a sticky done flag is set, and an optional interrupt follows that flag.

Top module: `spi_hdx_master`

## Requirements
- R1: After `rst_n` is released, `busy`, `done`, `irq` and `mosi` are 0, every `cs_n` bit is 1, and `sck` equals `cfg_cpol`.
- R2: While `cfg_en` is 0 or `cfg_srst_n` is 0:
  - `start` is ignored;
  - a running transaction is abandoned, so `busy` reads 0 one cycle later;
  - `done` is cleared;
  - all `cs_n` bits are driven high.
- R3: While the engine is enabled, `cs_n[i]` equals `cs_sel_n[i]` as it was one cycle earlier. This holds independently of transactions.
- R4: All write frames are sent before any read frame. During read frames `mosi` is held at 0. Frame counts `cfg_wr_cnt` and `cfg_rd_cnt` may each be 0 to 8.
- R5: Frame i uses the 3-bit length code at `cfg_wr_len[3i+2:3i]` (write) or `cfg_rd_len[3i+2:3i]` (read), and carries code+1 bits. The total number of SCK sampling edges equals the sum of all frame lengths.
- R6: Write frame i is taken from `wr_data[8i+7:8i]`, MSB first. A frame of n bits sends bits 7 down to 8-n.
- R7: Read frame i is received MSB first into `rd_data[8i+7:8i]`, right-justified, with the unused upper bits cleared.
- R8: Each SCK half period lasts 2^`cfg_div` core clock cycles.
- R9: SCK idles at `cfg_cpol`. Data is sampled on the rising SCK edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise.
  - With `cfg_cpha`=1, the first SCK edge comes `cfg_setup`+1 cycles after `busy` rises.
  - With `cfg_cpha`=0, it comes one half period later.
- R10: `busy` rises one cycle after an accepted start. `done` rises `cfg_hold`+1 cycles after the end of the last bit period. With `cfg_cpha`=1, that is `cfg_hold`+1+2^`cfg_div` cycles after the last SCK edge.
- R11: `busy` stays high for exactly the sum of:
  - `cfg_setup`+1;
  - two half periods per bit;
  - `cfg_gap` between successive frames of one direction;
  - `cfg_turn` once, when both counts are nonzero;
  - `cfg_hold`+1.
- R12: `done` is set when a transaction ends and stays set until a `done_clr` pulse clears it. `irq` equals `done` while `cfg_irq_en` is 1 and is 0 otherwise.
- R13: A `start` pulse while `busy` is high is ignored. A start with both frame counts 0 sets `done` on the next cycle without raising `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Engine enable |
| cfg_srst_n | input | 1 | Soft reset, active low |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cfg_div | input | 3 | SCK half period is 2^code cycles |
| cfg_setup | input | 8 | Setup delay minus one |
| cfg_hold | input | 8 | Hold delay minus one |
| cfg_gap | input | 8 | Idle cycles between frames |
| cfg_turn | input | 8 | Idle cycles between write and read phases |
| cfg_wr_cnt | input | 4 | Number of write frames |
| cfg_rd_cnt | input | 4 | Number of read frames |
| cfg_wr_len | input | 24 | Packed write length codes |
| cfg_rd_len | input | 24 | Packed read length codes |
| cfg_irq_en | input | 1 | Interrupt enable |
| wr_data | input | 64 | Write buffer bytes |
| start | input | 1 | One-cycle start request |
| done_clr | input | 1 | One-cycle done clear |
| cs_sel_n | input | 8 | Chip-select request bits, active low |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 8 | Chip selects, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt |
| rd_data | output | 64 | Read buffer bytes |

## Verification
All counts are in core clock cycles. An accepted `start` shows `busy` on the next cycle. The first SCK toggle is due `cfg_setup`+1 cycles later, plus one half period when `cfg_cpha` is 0. `done` appears one cycle after `busy` falls, and chip selects and `done_clr` act after one cycle.

The bench samples every output on the falling clock edge and indexes each sample from the first cycle in which `busy` is high. It records the indices of the first SCK toggle, the last SCK toggle and the `done` rise. It then compares each index, and the total count of `busy` cycles, against sums computed from the configuration.

The bench's slave model captures MOSI and advances MISO only on sampling-edge toggles. The value the engine captures is therefore held stable for a full half period around the edge at which it is sampled.

// File: rtl/spi_hdx_pkg.sv
`timescale 1ns/1ps
package spi_hdx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_BIT   = 3'd2,
    ST_GAP   = 3'd3,
    ST_TURN  = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/spi_hdx_seq.sv
`timescale 1ns/1ps
// Transaction sequencer: setup, bit periods, gaps, turnaround, hold.
module spi_hdx_seq
  import spi_hdx_pkg::*;
#(
  parameter int MAX_FRAMES = 8,
  parameter int CNT_W      = 8,
  localparam int FIDX_W    = $clog2(MAX_FRAMES + 1),
  localparam int FI_W      = $clog2(MAX_FRAMES),
  localparam int LEN_W     = 3 * MAX_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [2:0]        div_code,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  input  logic [CNT_W-1:0]  gap_cyc,
  input  logic [CNT_W-1:0]  turn_cyc,
  input  logic [FIDX_W-1:0] wr_cnt,
  input  logic [FIDX_W-1:0] rd_cnt,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              busy,
  output logic              sck,
  output logic              tx_on,
  output logic              rx_sample,
  output logic              rx_first,
  output logic [FI_W-1:0]   frame_idx,
  output logic [2:0]        bit_pos,
  output logic              done_set
);

  seq_state_t        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              phb_q, phb_n;
  logic [FI_W-1:0]   frame_q, frame_n;
  logic [2:0]        pos_q, pos_n;
  logic              rd_q, rd_n;

  logic [FIDX_W-1:0] wr_eff, rd_eff, dir_cnt;
  logic [CNT_W-1:0]  half_m1;
  logic [2:0]        cur_len, last_pos;
  logic              last_in_dir;

  always_comb begin
    wr_eff   = (wr_cnt > FIDX_W'(MAX_FRAMES)) ? FIDX_W'(MAX_FRAMES) : wr_cnt;
    rd_eff   = (rd_cnt > FIDX_W'(MAX_FRAMES)) ? FIDX_W'(MAX_FRAMES) : rd_cnt;
    dir_cnt  = rd_q ? rd_eff : wr_eff;
    half_m1  = (CNT_W'(1) << div_code) - CNT_W'(1);
    cur_len  = rd_q ? rd_len[frame_q*3 +: 3] : wr_len[frame_q*3 +: 3];
    last_pos = 3'd7 - cur_len;
    last_in_dir = (FIDX_W'(frame_q) == (dir_cnt - FIDX_W'(1)));
  end

  // Next-state process
  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    phb_n     = phb_q;
    frame_n   = frame_q;
    pos_n     = pos_q;
    rd_n      = rd_q;
    done_set  = 1'b0;
    rx_sample = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && run_ok) begin
          if (wr_eff == '0 && rd_eff == '0) begin
            done_set = 1'b1;
          end else begin
            state_n = ST_SETUP;
            cnt_n   = setup_cyc;
            rd_n    = (wr_eff == '0);
            frame_n = '0;
          end
        end
      end
      ST_SETUP, ST_GAP, ST_TURN: begin
        if (cnt_q == '0) begin
          state_n = ST_BIT;
          phb_n   = 1'b0;
          pos_n   = 3'd7;
          cnt_n   = half_m1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      ST_BIT: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CNT_W'(1);
        end else if (!phb_q) begin
          phb_n     = 1'b1;
          cnt_n     = half_m1;
          rx_sample = rd_q;
        end else if (pos_q != last_pos) begin
          phb_n = 1'b0;
          pos_n = pos_q - 3'd1;
          cnt_n = half_m1;
        end else if (!last_in_dir) begin
          frame_n = frame_q + FI_W'(1);
          phb_n   = 1'b0;
          pos_n   = 3'd7;
          if (gap_cyc == '0) begin
            cnt_n = half_m1;
          end else begin
            state_n = ST_GAP;
            cnt_n   = gap_cyc - CNT_W'(1);
          end
        end else if (!rd_q && rd_eff != '0) begin
          frame_n = '0;
          rd_n    = 1'b1;
          phb_n   = 1'b0;
          pos_n   = 3'd7;
          if (turn_cyc == '0) begin
            cnt_n = half_m1;
          end else begin
            state_n = ST_TURN;
            cnt_n   = turn_cyc - CNT_W'(1);
          end
        end else begin
          state_n = ST_HOLD;
          cnt_n   = hold_cyc;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_n  = ST_IDLE;
          done_set = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (!run_ok) begin
      state_n = ST_IDLE;
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phb_q   <= 1'b0;
      frame_q <= '0;
      pos_q   <= 3'd7;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      phb_q   <= phb_n;
      frame_q <= frame_n;
      pos_q   <= pos_n;
      rd_q    <= rd_n;
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    sck       = (state_q == ST_BIT) ? (cpol ^ cpha ^ phb_q) : cpol;
    tx_on     = (state_q == ST_BIT) && !rd_q;
    rx_first  = (pos_q == 3'd7);
    frame_idx = frame_q;
    bit_pos   = pos_q;
  end

endmodule

// File: rtl/spi_hdx_txmux.sv
`timescale 1ns/1ps
// Selects the outgoing bit from the write buffer.
module spi_hdx_txmux #(
  parameter int MAX_FRAMES = 8,
  localparam int FI_W      = $clog2(MAX_FRAMES)
) (
  input  logic [8*MAX_FRAMES-1:0] wr_data,
  input  logic [FI_W-1:0]         frame_idx,
  input  logic [2:0]              bit_pos,
  input  logic                    tx_on,
  output logic                    mosi
);
  always_comb begin
    mosi = tx_on & wr_data[{frame_idx, bit_pos}];
  end
endmodule

// File: rtl/spi_hdx_rxbuf.sv
`timescale 1ns/1ps
// Read buffer: one byte per frame, MSB-first shift, right-justified.
module spi_hdx_rxbuf #(
  parameter int MAX_FRAMES = 8,
  localparam int FI_W      = $clog2(MAX_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample,
  input  logic                    first,
  input  logic [FI_W-1:0]         frame_idx,
  input  logic                    miso,
  output logic [8*MAX_FRAMES-1:0] rd_data
);
  for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_byte
    logic [7:0] byte_q, byte_n;
    logic       hit;
    always_comb begin
      hit    = sample && (frame_idx == FI_W'(g));
      byte_n = first ? {7'b0, miso} : {byte_q[6:0], miso};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (hit) begin
        byte_q <= byte_n;
      end
    end
    assign rd_data[8*g +: 8] = byte_q;
  end
endmodule

// File: rtl/spi_hdx_csreg.sv
`timescale 1ns/1ps
// Registered chip selects, forced inactive when the engine is gated.
module spi_hdx_csreg #(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic [NUM_CS-1:0] sel_n,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0] cs_d;
  always_comb begin
    cs_d = run_ok ? sel_n : '1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= '1;
    end else begin
      cs_n <= cs_d;
    end
  end
endmodule

// File: rtl/spi_hdx_master.sv
`timescale 1ns/1ps
module spi_hdx_master #(
  parameter int MAX_FRAMES = 8,
  parameter int NUM_CS     = 8,
  parameter int CNT_W      = 8,
  localparam int FIDX_W    = $clog2(MAX_FRAMES + 1),
  localparam int FI_W      = $clog2(MAX_FRAMES),
  localparam int LEN_W     = 3 * MAX_FRAMES,
  localparam int BUF_W     = 8 * MAX_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_srst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [2:0]        cfg_div,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [CNT_W-1:0]  cfg_turn,
  input  logic [FIDX_W-1:0] cfg_wr_cnt,
  input  logic [FIDX_W-1:0] cfg_rd_cnt,
  input  logic [LEN_W-1:0]  cfg_wr_len,
  input  logic [LEN_W-1:0]  cfg_rd_len,
  input  logic              cfg_irq_en,
  input  logic [BUF_W-1:0]  wr_data,
  input  logic              start,
  input  logic              done_clr,
  input  logic [NUM_CS-1:0] cs_sel_n,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [BUF_W-1:0]  rd_data
);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic            run_ok;
  logic            tx_on, rx_sample, rx_first, done_set;
  logic [FI_W-1:0] frame_idx;
  logic [2:0]      bit_pos;
  logic            done_q, done_n;

  assign run_ok = cfg_en & cfg_srst_n;

  spi_hdx_seq #(.MAX_FRAMES(MAX_FRAMES), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_ok    (run_ok),
    .start     (start),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .div_code  (cfg_div),
    .setup_cyc (cfg_setup),
    .hold_cyc  (cfg_hold),
    .gap_cyc   (cfg_gap),
    .turn_cyc  (cfg_turn),
    .wr_cnt    (cfg_wr_cnt),
    .rd_cnt    (cfg_rd_cnt),
    .wr_len    (cfg_wr_len),
    .rd_len    (cfg_rd_len),
    .busy      (busy),
    .sck       (sck),
    .tx_on     (tx_on),
    .rx_sample (rx_sample),
    .rx_first  (rx_first),
    .frame_idx (frame_idx),
    .bit_pos   (bit_pos),
    .done_set  (done_set)
  );

  spi_hdx_txmux #(.MAX_FRAMES(MAX_FRAMES)) u_tx (
    .wr_data   (wr_data),
    .frame_idx (frame_idx),
    .bit_pos   (bit_pos),
    .tx_on     (tx_on),
    .mosi      (mosi)
  );

  spi_hdx_rxbuf #(.MAX_FRAMES(MAX_FRAMES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sample    (rx_sample),
    .first     (rx_first),
    .frame_idx (frame_idx),
    .miso      (miso),
    .rd_data   (rd_data)
  );

  spi_hdx_csreg #(.NUM_CS(NUM_CS)) u_cs (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_ok (run_ok),
    .sel_n  (cs_sel_n),
    .cs_n   (cs_n)
  );

  // Sticky done flag: completion outranks a simultaneous clear.
  always_comb begin
    done_n = done_q;
    if (!run_ok) begin
      done_n = 1'b0;
    end else if (done_set) begin
      done_n = 1'b1;
    end else if (done_clr) begin
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign irq  = done_q & cfg_irq_en;

endmodule

// File: rtl/spi_hdx_chk.sv
`timescale 1ns/1ps
module spi_hdx_chk #(
  parameter int NUM_CS = 8,
  parameter int FIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_srst_n,
  input logic              cfg_cpol,
  input logic              cfg_irq_en,
  input logic              start,
  input logic              done_clr,
  input logic [FIDX_W-1:0] wr_cnt,
  input logic [FIDX_W-1:0] rd_cnt,
  input logic [NUM_CS-1:0] cs_sel_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              sck
);
  logic run;
  assign run = cfg_en & cfg_srst_n;

  a_r9_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_cpol));

  a_r2_gate_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy);

  a_r2_gate_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cs_n == '1));

  a_r3_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cs_n == $past(cs_sel_n)));

  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr && run) |=> done);

  a_r12_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  a_r13_empty_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && run && wr_cnt == '0 && rd_cnt == '0) |=> (done && !busy));
endmodule

bind spi_hdx_master spi_hdx_chk #(.NUM_CS(NUM_CS), .FIDX_W(FIDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .cfg_en     (cfg_en),
  .cfg_srst_n (cfg_srst_n),
  .cfg_cpol   (cfg_cpol),
  .cfg_irq_en (cfg_irq_en),
  .start      (start),
  .done_clr   (done_clr),
  .wr_cnt     (cfg_wr_cnt),
  .rd_cnt     (cfg_rd_cnt),
  .cs_sel_n   (cs_sel_n),
  .cs_n       (cs_n),
  .busy       (busy),
  .done       (done),
  .irq        (irq),
  .sck        (sck)
);

// File: tb/tb_spi_hdx_master.sv
`timescale 1ns/1ps
module tb_spi_hdx_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_srst_n, cfg_cpol, cfg_cpha, cfg_irq_en;
  logic [2:0]  cfg_div;
  logic [7:0]  cfg_setup, cfg_hold, cfg_gap, cfg_turn;
  logic [3:0]  cfg_wr_cnt, cfg_rd_cnt;
  logic [23:0] cfg_wr_len, cfg_rd_len;
  logic [63:0] wr_data;
  logic        start, done_clr, miso;
  logic [7:0]  cs_sel_n;
  logic        sck, mosi, busy, done, irq;
  logic [7:0]  cs_n;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_hdx_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_srst_n(cfg_srst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_gap(cfg_gap),
    .cfg_turn(cfg_turn), .cfg_wr_cnt(cfg_wr_cnt), .cfg_rd_cnt(cfg_rd_cnt),
    .cfg_wr_len(cfg_wr_len), .cfg_rd_len(cfg_rd_len), .cfg_irq_en(cfg_irq_en),
    .wr_data(wr_data), .start(start), .done_clr(done_clr), .cs_sel_n(cs_sel_n),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
    .done(done), .irq(irq), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit sbit(input int k, input int seed);
    return 1'(((k * 13 + seed * 7 + (k >> 2)) % 5) < 2);
  endfunction

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check(done == 1'b0 && irq == 1'b0, "R12", "done after clear", done, 0);
  endtask

  task automatic run_txn(input int wc, input int rc, input int dv, input bit pol,
                         input bit pha, input int su, input int ho, input int gp,
                         input int tn, input logic [23:0] wl, input logic [23:0] rl,
                         input int seed, input bit restart);
    bit cap [0:255];
    int H, W, R, exp_busy, idx, k, busy_cnt, first_tog, second_tog, last_tog;
    int done_idx, off, n, got, expv, mosi_rd;
    bit prev, ie;
    H = 1 << dv;
    ie = seed[0];
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = 3'(dv);
    cfg_setup = 8'(su); cfg_hold = 8'(ho); cfg_gap = 8'(gp); cfg_turn = 8'(tn);
    cfg_wr_cnt = 4'(wc); cfg_rd_cnt = 4'(rc); cfg_wr_len = wl; cfg_rd_len = rl;
    cfg_irq_en = ie;
    for (int i = 0; i < 8; i++) wr_data[8*i +: 8] = 8'(seed * 37 + i * 91 + 5);
    W = 0; R = 0;
    for (int i = 0; i < wc; i++) W += int'(wl[3*i +: 3]) + 1;
    for (int i = 0; i < rc; i++) R += int'(rl[3*i +: 3]) + 1;
    exp_busy = su + 1 + 2 * H * (W + R) + gp * ((wc > 0 ? wc - 1 : 0) + (rc > 0 ? rc - 1 : 0))
             + ((wc > 0 && rc > 0) ? tn : 0) + ho + 1;
    miso = sbit(0, seed);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; k = 0; busy_cnt = 0; first_tog = -1; second_tog = -1; last_tog = -1;
    done_idx = -1; prev = pol; mosi_rd = 0;
    while (done_idx < 0 && idx < 20000) begin
      if (busy) busy_cnt++;
      if (sck != prev) begin
        if (first_tog < 0) first_tog = idx;
        else if (second_tog < 0) second_tog = idx;
        last_tog = idx;
        if (sck == (pol == pha)) begin
          cap[k & 255] = mosi;
          if (k >= W && mosi) mosi_rd++;
          k++;
          miso = sbit(k, seed);
        end
      end
      prev = sck;
      if (done) done_idx = idx;
      if (restart && idx == 3) start = 1'b1;
      if (restart && idx == 4) start = 1'b0;
      idx++;
      if (done_idx < 0) @(negedge clk);
    end
    check(done_idx >= 0, "R12", "done raised", done_idx, busy_cnt);
    check(busy_cnt == exp_busy, restart ? "R13" : "R11", "busy cycles", busy_cnt, exp_busy);
    check(done_idx == busy_cnt, "R10", "done after busy", done_idx, busy_cnt);
    check(k == W + R, "R5", "sampling edges", k, W + R);
    check(mosi_rd == 0, "R4", "mosi high in read phase", mosi_rd, 0);
    check(first_tog == su + 1 + (pha ? 0 : H), "R9", "first edge offset", first_tog,
          su + 1 + (pha ? 0 : H));
    check(done_idx - last_tog == ho + 1 + (pha ? H : 0), "R10", "last edge to done",
          done_idx - last_tog, ho + 1 + (pha ? H : 0));
    if (W + R >= 2 && int'(wl[2:0]) >= 1 && wc > 0)
      check(second_tog - first_tog == H, "R8", "half period", second_tog - first_tog, H);
    check(sck == pol, "R9", "sck idle level", sck, pol);
    check(irq == (ie & done), "R12", "irq level", irq, ie & done);
    off = 0;
    for (int i = 0; i < wc; i++) begin
      n = int'(wl[3*i +: 3]) + 1;
      got = 0;
      for (int j = 0; j < n; j++) got = (got << 1) | int'(cap[(off + j) & 255]);
      expv = int'(wr_data[8*i +: 8]) >> (8 - n);
      check(got == expv, "R6", "write frame", got, expv);
      off += n;
    end
    off = W;
    for (int i = 0; i < rc; i++) begin
      n = int'(rl[3*i +: 3]) + 1;
      expv = 0;
      for (int j = 0; j < n; j++) expv = (expv << 1) | int'(sbit(off + j, seed));
      check(int'(rd_data[8*i +: 8]) == expv, "R7", "read frame", rd_data[8*i +: 8], expv);
      off += n;
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R12", "done sticky", done, 1);
    clear_done();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b1; cfg_srst_n = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_irq_en = 1'b1; cfg_div = 3'd0; cfg_setup = 8'd0; cfg_hold = 8'd0; cfg_gap = 8'd0;
    cfg_turn = 8'd0; cfg_wr_cnt = 4'd0; cfg_rd_cnt = 4'd0; cfg_wr_len = '0; cfg_rd_len = '0;
    wr_data = '0; start = 1'b0; done_clr = 1'b0; miso = 1'b0; cs_sel_n = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && irq == 0, "R1", "busy/done/irq", {busy, done, irq}, 0);
    check(cs_n == 8'hFF, "R1", "cs_n", cs_n, 8'hFF);
    check(sck == 0 && mosi == 0, "R1", "sck/mosi", {sck, mosi}, 0);

    // R3 chip selects follow after one cycle
    cs_sel_n = 8'b1010_0110;
    @(negedge clk);
    check(cs_n == 8'b1010_0110, "R3", "cs_n follow", cs_n, 8'b1010_0110);
    cs_sel_n = 8'b1111_1110;
    @(negedge clk);
    check(cs_n == 8'b1111_1110, "R3", "cs_n follow", cs_n, 8'b1111_1110);

    // R13 empty transaction
    cfg_wr_cnt = 4'd0; cfg_rd_cnt = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1 && busy == 0, "R13", "empty txn done", {done, busy}, 2);
    // R2 disable clears done and releases chip selects
    cfg_en = 1'b0;
    @(negedge clk);
    check(done == 0 && cs_n == 8'hFF, "R2", "disable clears", {done, cs_n}, 9'h0FF);
    start = 1'b1;
    cfg_wr_cnt = 4'd1; cfg_wr_len = 24'o7;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0, "R2", "start ignored when disabled", {busy, done}, 0);
    cfg_en = 1'b1;
    @(negedge clk);

    // R2 soft reset abandons a running transaction
    cfg_div = 3'd2; cfg_wr_cnt = 4'd2; cfg_rd_cnt = 4'd1; cfg_wr_len = 24'o77; cfg_rd_len = 24'o7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1, "R2", "busy before soft reset", busy, 1);
    cfg_srst_n = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && cs_n == 8'hFF, "R2", "soft reset abort",
          {busy, done, cs_n}, 10'h0FF);
    cfg_srst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0, "R2", "no resume after soft reset", {busy, done}, 0);

    // Sweep modes and dividers over several frame layouts (R4..R12, R13 restart)
    for (int m = 0; m < 4; m++) begin
      for (int dv = 0; dv < 3; dv++) begin
        run_txn(2, 1, dv, m[1], m[0], 0, 0, 0, 0, 24'o77, 24'o7, m * 3 + dv, 1'b0);
        run_txn(3, 2, dv, m[1], m[0], 2, 1, 1, 3, 24'o306, 24'o52, m * 5 + dv + 1, 1'b0);
        run_txn(0, 3, dv, m[1], m[0], 1, 2, 2, 5, 24'o0, 24'o427, m * 7 + dv + 2, 1'b0);
        run_txn(8, 8, dv, m[1], m[0], 0, 3, 0, 1, 24'o76543210, 24'o01234567,
                m * 11 + dv + 3, 1'b1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule